// File: doc/BRIEF.md
# Microprogram Address Sequencer Slice

This block picks the address of the next microinstruction on every clock. Four candidates are available: a micro program counter that normally advances by one, a loadable address register, the newest entry of a small return stack, and a direct data input. A two-bit source code chooses among them, and the result leaves the block on `y`.

A separate stack control either leaves the return stack alone, pushes the current counter value, or pops the newest entry. Because the source code and the stack control are independent, microcode builds jumps, subroutine calls, returns and loops by pairing them. The stack has four entries and is circular, so an overflowing push overwrites the oldest entry and a pop brings that oldest entry back round to the far end.

A carry input decides whether the counter advances. A carry output shows that the selected address is all ones while the carry input is high. An active-low zero input forces the address to zero, and a synchronous reset clears the counter and the address register.

The named states are the stack-pointer position (a value modulo four) and the three stack actions HOLD, PUSH and POP. Their transitions are PUSH (pointer plus one), POP (pointer minus one) and HOLD (pointer kept).

Top module: `useq_slice`

## Requirements
- R1: `src_sel` picks `y`: 2'b00 is the counter, 2'b01 is the address register, 2'b10 is the newest stack entry, and 2'b11 is `d_in`.
- R2: While `zero_n` is low, `y` is zero whatever `src_sel` holds.
- R3: At each rising edge outside reset, the counter loads `y + 1` (modulo 16) when `carry_in` is high, and loads `y` unchanged when it is low.
- R4: `carry_out` is high exactly when `carry_in` is high and `y` is 4'b1111.
- R5: While `stk_hold` is high, the stack contents and their order stay unchanged across the edge.
- R6: With `stk_hold` low and `stk_push` high, the counter value from before the edge becomes the newest entry, and the older entries each move one place deeper.
- R7: With `stk_hold` low and `stk_push` low, the second-newest entry becomes the newest. The former newest entry moves to the deepest place, so (a,b,c,d) becomes (b,c,d,a).
- R8: A push onto a full stack (a,b,c,d) gives (j,a,b,c) and drops d.
- R9: A return, which selects the stack and pops in the same cycle, puts the old newest entry on `y`. The counter then follows from that address.
- R10: A call, which selects `d_in` or the address register and pushes in the same cycle, puts the target on `y`. It saves on the stack the counter value from before the edge, which is the address that follows the call.
- R11: The address register loads `d_in` at a rising edge when `areg_ld_n` is low, and keeps its value otherwise.
- R12: A synchronous reset clears the counter and the address register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| src_sel | input | 2 | Next-address source code |
| stk_hold | input | 1 | High: no stack action |
| stk_push | input | 1 | When `stk_hold` is low: high pushes, low pops |
| carry_in | input | 1 | High advances the counter |
| areg_ld_n | input | 1 | Address-register load, active low |
| zero_n | input | 1 | Forces `y` to zero, active low |
| d_in | input | 4 | Direct address / address-register data |
| y | output | 4 | Selected next address |
| carry_out | output | 1 | Carry for a wider counter |

## Verification
The assertions assume that the stack control and source inputs hold known levels at every sampled edge. They also assume that a stack entry is read only after a push has written it, because the stack file itself has no reset. To stay within these assumptions, the stimulus fills all four entries with pushes of known counter values before it ever selects the stack. It then sweeps every combination of source, stack action, carry, zero and load, across all sixteen data values. Expected results come from a shifting four-place model that is independent of any pointer.

// File: rtl/useq_pkg.sv
package useq_pkg;

    typedef enum logic [1:0] {
        SRC_UPC   = 2'b00,
        SRC_AREG  = 2'b01,
        SRC_STACK = 2'b10,
        SRC_DATA  = 2'b11
    } src_e;

    typedef enum logic [1:0] {
        OP_HOLD = 2'b00,
        OP_PUSH = 2'b01,
        OP_POP  = 2'b10
    } stk_op_e;

endpackage

// File: rtl/useq_src_mux.sv
module useq_src_mux
    import useq_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  src_e              sel,
    input  logic              zero_n,
    input  logic [ADDR_W-1:0] upc,
    input  logic [ADDR_W-1:0] areg,
    input  logic [ADDR_W-1:0] top,
    input  logic [ADDR_W-1:0] data,
    output logic [ADDR_W-1:0] y
);

    logic [ADDR_W-1:0] pick;

    always_comb begin
        unique case (sel)
            SRC_UPC:   pick = upc;
            SRC_AREG:  pick = areg;
            SRC_STACK: pick = top;
            SRC_DATA:  pick = data;
            default:   pick = upc;
        endcase
    end

    assign y = zero_n ? pick : '0;

endmodule

// File: rtl/useq_upc.sv
module useq_upc #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] y,
    input  logic              cin,
    output logic [ADDR_W-1:0] upc,
    output logic              cout
);

    logic [ADDR_W-1:0] upc_q;
    logic [ADDR_W-1:0] upc_d;

    always_comb begin
        upc_d = y + {{(ADDR_W-1){1'b0}}, cin};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            upc_q <= '0;
        end else begin
            upc_q <= upc_d;
        end
    end

    assign upc  = upc_q;
    assign cout = cin & (&y);

endmodule

// File: rtl/useq_areg.sv
module useq_areg #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_n,
    input  logic [ADDR_W-1:0] d,
    output logic [ADDR_W-1:0] q
);

    logic [ADDR_W-1:0] q_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_r <= '0;
        end else if (!ld_n) begin
            q_r <= d;
        end
    end

    assign q = q_r;

endmodule

// File: rtl/useq_stack.sv
module useq_stack
    import useq_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DEPTH  = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  stk_op_e           op,
    input  logic [ADDR_W-1:0] push_val,
    output logic [ADDR_W-1:0] top,
    output logic [PTR_W-1:0]  ptr
);

    logic [ADDR_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  ptr_q;
    logic [PTR_W-1:0]  ptr_d;

    // next pointer per stack action
    always_comb begin
        unique case (op)
            OP_PUSH: ptr_d = ptr_q + PTR_W'(1);
            OP_POP:  ptr_d = ptr_q - PTR_W'(1);
            OP_HOLD: ptr_d = ptr_q;
            default: ptr_d = ptr_q;
        endcase
    end

    // pointer state register
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    // entry file: a push writes the slot the pointer moves to
    always_ff @(posedge clk) begin
        if (!rst && op == OP_PUSH) begin
            mem[ptr_d] <= push_val;
        end
    end

    assign top = mem[ptr_q];
    assign ptr = ptr_q;

endmodule

// File: rtl/useq_slice.sv
module useq_slice
    import useq_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DEPTH  = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        src_sel,
    input  logic              stk_hold,
    input  logic              stk_push,
    input  logic              carry_in,
    input  logic              areg_ld_n,
    input  logic              zero_n,
    input  logic [ADDR_W-1:0] d_in,
    output logic [ADDR_W-1:0] y,
    output logic              carry_out
);

    stk_op_e           stk_op;
    logic [ADDR_W-1:0] upc_q;
    logic [ADDR_W-1:0] areg_q;
    logic [ADDR_W-1:0] stk_top;
    logic [PTR_W-1:0]  stk_ptr;

    always_comb begin
        if (stk_hold) begin
            stk_op = OP_HOLD;
        end else if (stk_push) begin
            stk_op = OP_PUSH;
        end else begin
            stk_op = OP_POP;
        end
    end

    useq_src_mux #(.ADDR_W(ADDR_W)) u_mux (
        .sel    (src_e'(src_sel)),
        .zero_n (zero_n),
        .upc    (upc_q),
        .areg   (areg_q),
        .top    (stk_top),
        .data   (d_in),
        .y      (y)
    );

    useq_upc #(.ADDR_W(ADDR_W)) u_upc (
        .clk  (clk),
        .rst  (rst),
        .y    (y),
        .cin  (carry_in),
        .upc  (upc_q),
        .cout (carry_out)
    );

    useq_areg #(.ADDR_W(ADDR_W)) u_areg (
        .clk  (clk),
        .rst  (rst),
        .ld_n (areg_ld_n),
        .d    (d_in),
        .q    (areg_q)
    );

    useq_stack #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_stack (
        .clk      (clk),
        .rst      (rst),
        .op       (stk_op),
        .push_val (upc_q),
        .top      (stk_top),
        .ptr      (stk_ptr)
    );

endmodule

// File: rtl/useq_slice_chk.sv
module useq_slice_chk #(
    parameter int ADDR_W = 4,
    parameter int PTR_W  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        src_sel,
    input logic              stk_hold,
    input logic              stk_push,
    input logic              carry_in,
    input logic              areg_ld_n,
    input logic              zero_n,
    input logic [ADDR_W-1:0] d_in,
    input logic [ADDR_W-1:0] y,
    input logic              carry_out,
    input logic [ADDR_W-1:0] upc_q,
    input logic [ADDR_W-1:0] areg_q,
    input logic [ADDR_W-1:0] stk_top,
    input logic [PTR_W-1:0]  stk_ptr
);

    a_r2_zero_forces: assert property (@(posedge clk) disable iff (rst)
        !zero_n |-> (y == '0));

    a_r1_data_source: assert property (@(posedge clk) disable iff (rst)
        (zero_n && src_sel == 2'b11) |-> (y == d_in));

    a_r3_counter_next: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (upc_q == $past(y) + {{(ADDR_W-1){1'b0}}, $past(carry_in)}));

    a_r4_carry_out: assert property (@(posedge clk) disable iff (rst)
        carry_out |-> (carry_in && (y == {ADDR_W{1'b1}})));

    a_r5_hold_ptr: assert property (@(posedge clk) disable iff (rst)
        (!rst && stk_hold) |=> $stable(stk_ptr));

    a_r6_push_top: assert property (@(posedge clk) disable iff (rst)
        (!rst && !stk_hold && stk_push) |=> (stk_top == $past(upc_q)));

    a_r11_areg_keep: assert property (@(posedge clk) disable iff (rst)
        (!rst && areg_ld_n) |=> (areg_q == $past(areg_q)));

    a_r11_areg_load: assert property (@(posedge clk) disable iff (rst)
        (!rst && !areg_ld_n) |=> (areg_q == $past(d_in)));

    a_r12_reset_clear: assert property (@(posedge clk)
        rst |=> (upc_q == '0 && areg_q == '0));

endmodule

bind useq_slice useq_slice_chk #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .src_sel   (src_sel),
    .stk_hold  (stk_hold),
    .stk_push  (stk_push),
    .carry_in  (carry_in),
    .areg_ld_n (areg_ld_n),
    .zero_n    (zero_n),
    .d_in      (d_in),
    .y         (y),
    .carry_out (carry_out),
    .upc_q     (upc_q),
    .areg_q    (areg_q),
    .stk_top   (stk_top),
    .stk_ptr   (stk_ptr)
);

// File: tb/useq_slice_tb.sv
module useq_slice_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] src_sel;
    logic       stk_hold;
    logic       stk_push;
    logic       carry_in;
    logic       areg_ld_n;
    logic       zero_n;
    logic [3:0] d_in;
    logic [3:0] y;
    logic       carry_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // bench model: shifting view, index 0 = newest
    logic [3:0] m_upc;
    logic [3:0] m_areg;
    logic [3:0] m_view [4];

    always #4 clk = ~clk;

    useq_slice u_dut (
        .clk       (clk),
        .rst       (rst),
        .src_sel   (src_sel),
        .stk_hold  (stk_hold),
        .stk_push  (stk_push),
        .carry_in  (carry_in),
        .areg_ld_n (areg_ld_n),
        .zero_n    (zero_n),
        .d_in      (d_in),
        .y         (y),
        .carry_out (carry_out)
    );

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // op: 0 hold, 1 push, 2 pop
    task automatic step(input logic [1:0] s, input int op, input logic c,
                        input logic z, input logic ld, input logic [3:0] dv,
                        input string tag);
        logic [3:0] ye;
        logic       ce;
        string      t;
        @(negedge clk);
        src_sel   = s;
        stk_hold  = (op == 0);
        stk_push  = (op == 1);
        carry_in  = c;
        zero_n    = z;
        areg_ld_n = ld;
        d_in      = dv;
        #1;
        if (!z) begin
            ye = 4'h0;
        end else begin
            case (s)
                2'b00:   ye = m_upc;
                2'b01:   ye = m_areg;
                2'b10:   ye = m_view[0];
                default: ye = dv;
            endcase
        end
        ce = c && (ye == 4'hF);
        if (tag != "") t = tag;
        else if (!z) t = "R2";
        else if (s == 2'b00) t = "R3";
        else if (s == 2'b01) t = "R11";
        else if (s == 2'b10) t = "R7";
        else t = "R1";
        chk(t, y, ye);
        chk("R4", {3'b000, carry_out}, {3'b000, ce});
        if (op == 1) begin
            m_view[3] = m_view[2];
            m_view[2] = m_view[1];
            m_view[1] = m_view[0];
            m_view[0] = m_upc;
        end else if (op == 2) begin
            logic [3:0] old0;
            old0      = m_view[0];
            m_view[0] = m_view[1];
            m_view[1] = m_view[2];
            m_view[2] = m_view[3];
            m_view[3] = old0;
        end
        m_upc = ye + {3'b000, c};
        if (!ld) m_areg = dv;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; src_sel = 2'b00; stk_hold = 1'b1; stk_push = 1'b0;
        carry_in = 1'b0; areg_ld_n = 1'b1; zero_n = 1'b1; d_in = 4'h0;
        m_upc = 4'h0; m_areg = 4'h0;
        for (int i = 0; i < 4; i++) m_view[i] = 4'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R12", y, 4'h0);
        src_sel = 2'b01;
        #1;
        chk("R12", y, 4'h0);

        // fill all four entries with known counter values (R6)
        step(2'b11, 1, 1'b1, 1'b1, 1'b1, 4'h2, "R1");
        step(2'b11, 1, 1'b1, 1'b1, 1'b1, 4'h6, "R1");
        step(2'b11, 1, 1'b1, 1'b1, 1'b1, 4'hA, "R1");
        step(2'b11, 1, 1'b1, 1'b1, 1'b1, 4'hD, "R1");
        step(2'b10, 0, 1'b0, 1'b1, 1'b1, 4'h0, "R6");

        // hold keeps the top (R5)
        step(2'b10, 0, 1'b1, 1'b1, 1'b1, 4'h0, "R5");
        step(2'b10, 0, 1'b1, 1'b1, 1'b1, 4'h0, "R5");

        // call via d_in then return (R10, R9)
        step(2'b11, 0, 1'b1, 1'b1, 1'b1, 4'h3, "R1");
        step(2'b11, 1, 1'b1, 1'b1, 1'b1, 4'h9, "R10");
        step(2'b10, 0, 1'b1, 1'b1, 1'b1, 4'h0, "R10");
        step(2'b10, 2, 1'b1, 1'b1, 1'b1, 4'h0, "R9");
        step(2'b00, 0, 1'b1, 1'b1, 1'b1, 4'h0, "R9");

        // call via address register (R10, R11)
        step(2'b11, 0, 1'b1, 1'b1, 1'b0, 4'hC, "R11");
        step(2'b01, 1, 1'b1, 1'b1, 1'b1, 4'h0, "R10");
        step(2'b10, 2, 1'b1, 1'b1, 1'b1, 4'h0, "R9");

        // overflow wrap: five pushes then read back by pops (R8, R7)
        for (int k = 0; k < 5; k++) step(2'b11, 1, 1'b1, 1'b1, 1'b1, 4'(k * 3), "R8");
        for (int k = 0; k < 5; k++) step(2'b10, 2, 1'b0, 1'b1, 1'b1, 4'h0, "R8");

        // carry wrap at all ones (R3, R4)
        step(2'b11, 0, 1'b1, 1'b1, 1'b1, 4'hF, "R4");
        step(2'b00, 0, 1'b0, 1'b1, 1'b1, 4'h0, "R3");
        step(2'b00, 0, 1'b0, 1'b1, 1'b1, 4'h0, "R3");

        // full sweep of all control combinations
        for (int dv = 0; dv < 16; dv++)
            for (int ld = 0; ld < 2; ld++)
                for (int z = 0; z < 2; z++)
                    for (int c = 0; c < 2; c++)
                        for (int op = 0; op < 3; op++)
                            for (int s = 0; s < 4; s++)
                                step(2'(s), op, 1'(c), 1'(z), 1'(ld), 4'(dv), "");

        // synchronous reset clears counter and register (R12)
        step(2'b11, 0, 1'b1, 1'b1, 1'b0, 4'h7, "R11");
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        src_sel = 2'b00; zero_n = 1'b1;
        #1;
        chk("R12", y, 4'h0);
        src_sel = 2'b01;
        #1;
        chk("R12", y, 4'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule